// File: doc/BRIEF.md
# Compute-Region Resource Tracker

This block keeps the books for an accelerator built from many compute regions. It holds a one-bit-per-region free table and a small kernel table. Each kernel entry records the kernel's identifier, the bitmap of regions it asked for, the regions it holds now, a streaming flag and a lifecycle state. A launch request carries a kernel identifier, a region bitmap and a streaming flag. One cycle later the block answers with a positive or a negative acknowledge.

A granted kernel takes every requested region that is free at once. It then picks up the rest as other kernels release them, so programming can begin before the whole set is available. Separate event channels report programming and execution progress, and completion or termination, for a kernel identifier. A global flush aborts all work. Within one cycle the block settles contention in a fixed order. Completions release first. Kernels already being programmed claim next, lowest table slot first. New requests see whatever is left. A lookup port returns the state of any kernel identifier.

Top module: `cr_tracker`

## Requirements
- R1: After reset every bit of `free_map` is 1, both acknowledge outputs are 0 and a lookup reports no hit.
- R2: Each cycle with `req_valid` high produces, on the following cycle, exactly one of `ack_pos` or `ack_neg`, with `ack_kid` echoing the identifier. The answer is positive only when at least one requested region is still free after completions and claims of that cycle, no flush is present, a table slot is open and the identifier is not held by a live kernel.
- R3: On a positive acknowledge the requested regions that were free are cleared in `free_map` and the entry reads state 1 (ready to program). A negative acknowledge changes no entry.
- R4: A kernel in state 1 or 2 claims each requested region as soon as it is free. When several kernels want the same region, the lowest table slot wins.
- R5: `pg_op` 0 (programming start) moves a kernel from state 1 to state 2 (partially programmed). A kernel in state 2 moves to state 3 (completely programmed) once it holds every requested region and `pg_op` 1 (programming done) has been seen.
- R6: `pg_op` 2 (execution start) moves a kernel from state 3 to state 4 (execute). Programming events that do not match the kernel's state, and `pg_op` 3, are ignored.
- R7: A completion with `cmp_term` 0 on a non-streaming kernel in state 4 frees all its regions and its entry, after which lookups miss. On a streaming kernel it leaves state and regions unchanged.
- R8: A completion with `cmp_term` 1 releases a streaming kernel in state 4. It has no effect on a non-streaming kernel.
- R9: Regions and table slots released in a cycle are visible, in that same cycle, to claims by existing kernels and then to the new request.
- R10: `flush` returns every region to free and every entry to free on the next edge. A request in the same cycle is answered negatively.
- R11: A request is answered negatively when all table slots hold live kernels, or when its identifier is already live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Abort all kernels, free all regions |
| req_valid | input | 1 | Launch request strobe |
| req_kid | input | KID_W | Requesting kernel identifier |
| req_map | input | NUM_CR | Regions requested, bit i = region i |
| req_stream | input | 1 | Requesting kernel is streaming |
| pg_valid | input | 1 | Programming-channel event strobe |
| pg_kid | input | KID_W | Kernel the programming event refers to |
| pg_op | input | 2 | 0 start, 1 done, 2 execution start, 3 none |
| cmp_valid | input | 1 | Completion-channel event strobe |
| cmp_kid | input | KID_W | Kernel the completion refers to |
| cmp_term | input | 1 | 0 execution over, 1 terminate |
| qry_kid | input | KID_W | Kernel identifier to look up |
| ack_pos | output | 1 | Request granted |
| ack_neg | output | 1 | Request refused |
| ack_kid | output | KID_W | Identifier the acknowledge answers |
| free_map | output | NUM_CR | Free table, 1 = region free |
| qry_hit | output | 1 | Looked-up identifier is live |
| qry_state | output | 3 | State of looked-up kernel, 0 when no hit |

## Verification
A corrupted owned set or a wrong lifecycle state shows up at `free_map`. Regions either never come back or reappear while still owned, and this is visible one edge after the completion or claim that should have moved them. A wrong state also changes the next acknowledge, because table slots and duplicate identifiers decide grants, and a lookup exposes it two edges after the event. Same-cycle ordering faults show as a request refused, or a region lost to the wrong slot, in the very cycle that regions are released.

// File: rtl/cr_trk_pkg.sv
package cr_trk_pkg;

  typedef enum logic [2:0] {
    KS_FREE = 3'd0,
    KS_RTP  = 3'd1,
    KS_PP   = 3'd2,
    KS_CP   = 3'd3,
    KS_EXEC = 3'd4
  } kstate_t;

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_DONE  = 2'd1;
  localparam logic [1:0] OP_EXEC  = 2'd2;

endpackage

// File: rtl/cr_free_table.sv
module cr_free_table #(
  parameter int NUM_CR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [NUM_CR-1:0] rel_all,
  input  logic [NUM_CR-1:0] claim_all,
  output logic [NUM_CR-1:0] avail_base,
  output logic [NUM_CR-1:0] free_q
);

  // released regions are seen by this cycle's readers
  always_comb avail_base = free_q | rel_all;

  always_ff @(posedge clk) begin
    if (rst || flush) free_q <= '1;
    else              free_q <= avail_base & ~claim_all;
  end

  AST_FLUSH_FREES_ALL: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (free_q == '1)); // R10

  AST_CLAIM_FROM_AVAIL: assert property (@(posedge clk) disable iff (rst)
    ((claim_all & ~avail_base) == '0)); // R4

  AST_RELEASE_LANDS: assert property (@(posedge clk) disable iff (rst)
    ((rel_all & ~claim_all) != '0) |=>
      ((free_q & $past(rel_all & ~claim_all)) == $past(rel_all & ~claim_all))); // R7

endmodule

// File: rtl/cr_kernel_slot.sv
module cr_kernel_slot
  import cr_trk_pkg::*;
#(
  parameter int NUM_CR = 16,
  parameter int KID_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              pg_valid,
  input  logic [KID_W-1:0]  pg_kid,
  input  logic [1:0]        pg_op,
  input  logic              cmp_valid,
  input  logic [KID_W-1:0]  cmp_kid,
  input  logic              cmp_term,
  input  logic [NUM_CR-1:0] avail,
  input  logic              alloc,
  input  logic [KID_W-1:0]  alloc_kid,
  input  logic [NUM_CR-1:0] alloc_map,
  input  logic [NUM_CR-1:0] alloc_take,
  input  logic              alloc_stream,
  output logic [NUM_CR-1:0] take,
  output logic [NUM_CR-1:0] rel_map,
  output logic              retire,
  output logic              live,
  output logic [KID_W-1:0]  kid_o,
  output kstate_t           state_o,
  output logic [NUM_CR-1:0] owned_o
);

  kstate_t           state_q;
  logic [NUM_CR-1:0] need_q;
  logic [NUM_CR-1:0] own_q;
  logic [KID_W-1:0]  kid_q;
  logic              strm_q;
  logic              pseen_q;

  logic hit_pg, hit_cmp, claiming, done_now, full;

  always_comb begin
    live     = (state_q != KS_FREE);
    hit_pg   = pg_valid && live && (pg_kid == kid_q);
    hit_cmp  = cmp_valid && live && (cmp_kid == kid_q);
    claiming = (state_q == KS_RTP) || (state_q == KS_PP);
    take     = claiming ? (need_q & ~own_q & avail) : '0;
    retire   = hit_cmp && (state_q == KS_EXEC) && (cmp_term == strm_q);
    rel_map  = retire ? own_q : '0;
    done_now = hit_pg && (pg_op == OP_DONE);
    full     = ((own_q | take) == need_q);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state_q <= KS_FREE;
      need_q  <= '0;
      own_q   <= '0;
      kid_q   <= '0;
      strm_q  <= 1'b0;
      pseen_q <= 1'b0;
    end else if (alloc) begin
      state_q <= KS_RTP;
      kid_q   <= alloc_kid;
      need_q  <= alloc_map;
      own_q   <= alloc_take;
      strm_q  <= alloc_stream;
      pseen_q <= 1'b0;
    end else begin
      own_q <= own_q | take;
      if (state_q == KS_PP && done_now) pseen_q <= 1'b1;
      case (state_q)
        KS_RTP:  if (hit_pg && pg_op == OP_START) state_q <= KS_PP;
        KS_PP:   if (full && (pseen_q || done_now)) state_q <= KS_CP;
        KS_CP:   if (hit_pg && pg_op == OP_EXEC) state_q <= KS_EXEC;
        KS_EXEC: if (retire) begin
                   state_q <= KS_FREE;
                   own_q   <= '0;
                 end
        default: ;
      endcase
    end
  end

  assign kid_o   = kid_q;
  assign state_o = state_q;
  assign owned_o = own_q;

  AST_CP_OWNS_ALL: assert property (@(posedge clk) disable iff (rst)
    (state_q == KS_CP) |-> (own_q == need_q)); // R5

  AST_EXEC_FROM_CP: assert property (@(posedge clk) disable iff (rst)
    (state_q == KS_EXEC && $past(state_q) != KS_EXEC) |-> ($past(state_q) == KS_CP)); // R6

  AST_ALLOC_WHEN_OPEN: assert property (@(posedge clk) disable iff (rst)
    alloc |-> (!live || retire)); // R11

endmodule

// File: rtl/cr_req_unit.sv
module cr_req_unit #(
  parameter int NUM_CR  = 16,
  parameter int NUM_KRN = 4,
  parameter int KID_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               req_valid,
  input  logic [KID_W-1:0]   req_kid,
  input  logic [NUM_CR-1:0]  req_map,
  input  logic [NUM_KRN-1:0] slot_live,
  input  logic [NUM_KRN-1:0] slot_retire,
  input  logic [KID_W-1:0]   slot_kid [NUM_KRN],
  input  logic [NUM_CR-1:0]  avail,
  output logic [NUM_KRN-1:0] alloc,
  output logic [NUM_CR-1:0]  alloc_take,
  output logic               ack_pos,
  output logic               ack_neg,
  output logic [KID_W-1:0]   ack_kid
);

  logic [NUM_KRN-1:0] open_slot, pick;
  logic               dup, found, accept;
  logic [NUM_CR-1:0]  grant;

  always_comb begin
    open_slot = ~slot_live | slot_retire;
    dup   = 1'b0;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_KRN; i++) begin
      if (slot_live[i] && !slot_retire[i] && slot_kid[i] == req_kid) dup = 1'b1;
      if (open_slot[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
    grant      = req_map & avail;
    accept     = req_valid && !flush && (|grant) && found && !dup;
    alloc      = accept ? pick : '0;
    alloc_take = accept ? grant : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_pos <= 1'b0;
      ack_neg <= 1'b0;
      ack_kid <= '0;
    end else begin
      ack_pos <= accept;
      ack_neg <= req_valid && !accept;
      ack_kid <= req_kid;
    end
  end

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (ack_pos || ack_neg) |-> $past(req_valid)); // R2

  AST_FLUSH_REFUSES: assert property (@(posedge clk) disable iff (rst)
    $past(flush && req_valid) |-> (ack_neg && !ack_pos)); // R10

endmodule

// File: rtl/cr_tracker.sv
module cr_tracker
  import cr_trk_pkg::*;
#(
  parameter int NUM_CR  = 16,
  parameter int NUM_KRN = 4,
  parameter int KID_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [KID_W-1:0]  req_kid,
  input  logic [NUM_CR-1:0] req_map,
  input  logic              req_stream,
  input  logic              pg_valid,
  input  logic [KID_W-1:0]  pg_kid,
  input  logic [1:0]        pg_op,
  input  logic              cmp_valid,
  input  logic [KID_W-1:0]  cmp_kid,
  input  logic              cmp_term,
  input  logic [KID_W-1:0]  qry_kid,
  output logic              ack_pos,
  output logic              ack_neg,
  output logic [KID_W-1:0]  ack_kid,
  output logic [NUM_CR-1:0] free_map,
  output logic              qry_hit,
  output logic [2:0]        qry_state
);

  logic [NUM_CR-1:0]  chain  [NUM_KRN+1];
  logic [NUM_CR-1:0]  take   [NUM_KRN];
  logic [NUM_CR-1:0]  rel    [NUM_KRN];
  logic [NUM_CR-1:0]  owned  [NUM_KRN];
  logic [KID_W-1:0]   skid   [NUM_KRN];
  kstate_t            sstate [NUM_KRN];
  logic [NUM_KRN-1:0] retire, live, alloc;
  logic [NUM_CR-1:0]  avail_base, alloc_take, rel_all, claim_all, owned_all;

  cr_free_table #(.NUM_CR(NUM_CR)) u_free (
    .clk(clk), .rst(rst), .flush(flush),
    .rel_all(rel_all), .claim_all(claim_all),
    .avail_base(avail_base), .free_q(free_map)
  );

  assign chain[0] = avail_base;

  for (genvar g = 0; g < NUM_KRN; g++) begin : g_slot
    assign chain[g+1] = chain[g] & ~take[g];

    cr_kernel_slot #(.NUM_CR(NUM_CR), .KID_W(KID_W)) u_slot (
      .clk(clk), .rst(rst), .flush(flush),
      .pg_valid(pg_valid), .pg_kid(pg_kid), .pg_op(pg_op),
      .cmp_valid(cmp_valid), .cmp_kid(cmp_kid), .cmp_term(cmp_term),
      .avail(chain[g]),
      .alloc(alloc[g]), .alloc_kid(req_kid), .alloc_map(req_map),
      .alloc_take(alloc_take), .alloc_stream(req_stream),
      .take(take[g]), .rel_map(rel[g]), .retire(retire[g]), .live(live[g]),
      .kid_o(skid[g]), .state_o(sstate[g]), .owned_o(owned[g])
    );
  end

  cr_req_unit #(.NUM_CR(NUM_CR), .NUM_KRN(NUM_KRN), .KID_W(KID_W)) u_req (
    .clk(clk), .rst(rst), .flush(flush),
    .req_valid(req_valid), .req_kid(req_kid), .req_map(req_map),
    .slot_live(live), .slot_retire(retire), .slot_kid(skid),
    .avail(chain[NUM_KRN]),
    .alloc(alloc), .alloc_take(alloc_take),
    .ack_pos(ack_pos), .ack_neg(ack_neg), .ack_kid(ack_kid)
  );

  logic       q_hit_d;
  logic [2:0] q_st_d;

  always_comb begin
    rel_all   = '0;
    claim_all = alloc_take;
    owned_all = '0;
    q_hit_d   = 1'b0;
    q_st_d    = 3'd0;
    for (int i = 0; i < NUM_KRN; i++) begin
      rel_all   = rel_all | rel[i];
      claim_all = claim_all | take[i];
      owned_all = owned_all | owned[i];
      if (live[i] && skid[i] == qry_kid) begin
        q_hit_d = 1'b1;
        q_st_d  = sstate[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qry_hit   <= 1'b0;
      qry_state <= 3'd0;
    end else begin
      qry_hit   <= q_hit_d;
      qry_state <= q_st_d;
    end
  end

  AST_OWNED_IS_BUSY: assert property (@(posedge clk) disable iff (rst)
    ((owned_all & free_map) == '0)); // R3

endmodule

// File: tb/test_cr_tracker.sv
`timescale 1ns/1ps
module test_cr_tracker;
  localparam int NC = 16;
  localparam int NK = 4;
  localparam int KW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic req_valid = 1'b0;
  logic [KW-1:0] req_kid = '0;
  logic [NC-1:0] req_map = '0;
  logic req_stream = 1'b0;
  logic pg_valid = 1'b0;
  logic [KW-1:0] pg_kid = '0;
  logic [1:0] pg_op = 2'd3;
  logic cmp_valid = 1'b0;
  logic [KW-1:0] cmp_kid = '0;
  logic cmp_term = 1'b0;
  logic [KW-1:0] qry_kid = '0;
  logic ack_pos, ack_neg, qry_hit;
  logic [KW-1:0] ack_kid;
  logic [NC-1:0] free_map;
  logic [2:0] qry_state;

  always #10 clk = ~clk;

  cr_tracker #(.NUM_CR(NC), .NUM_KRN(NK), .KID_W(KW)) i_cr_tracker (
    .clk(clk), .rst(rst), .flush(flush),
    .req_valid(req_valid), .req_kid(req_kid), .req_map(req_map), .req_stream(req_stream),
    .pg_valid(pg_valid), .pg_kid(pg_kid), .pg_op(pg_op),
    .cmp_valid(cmp_valid), .cmp_kid(cmp_kid), .cmp_term(cmp_term),
    .qry_kid(qry_kid),
    .ack_pos(ack_pos), .ack_neg(ack_neg), .ack_kid(ack_kid),
    .free_map(free_map), .qry_hit(qry_hit), .qry_state(qry_state)
  );

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // reference model of the kernel table
  int            m_st   [NK];
  logic [KW-1:0] m_kid  [NK];
  logic [NC-1:0] m_need [NK];
  logic [NC-1:0] m_own  [NK];
  bit            m_strm [NK];
  bit            m_ps   [NK];
  logic [NC-1:0] m_free;
  bit e_pos, e_neg, e_hit;
  logic [KW-1:0] e_kid;
  int e_qst;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NK; k++) begin
      m_st[k] = 0; m_own[k] = '0; m_need[k] = '0; m_kid[k] = '0;
      m_strm[k] = 0; m_ps[k] = 0;
    end
    m_free = '1;
  endtask

  function automatic int model_lookup(input logic [KW-1:0] kid, output bit hit);
    hit = 0;
    for (int k = 0; k < NK; k++)
      if (m_st[k] != 0 && m_kid[k] == kid) begin hit = 1; return m_st[k]; end
    return 0;
  endfunction

  task automatic model_step();
    bit ret [NK];
    int nst [NK];
    logic [NC-1:0] rel, av, tk, grant;
    bit dup, found, hitp;
    int slot;
    e_kid = req_kid;
    if (flush) begin
      model_reset();
      e_pos = 0; e_neg = req_valid;
      return;
    end
    rel = '0;
    for (int k = 0; k < NK; k++) begin
      ret[k] = (cmp_valid && m_st[k] == 4 && cmp_kid == m_kid[k] && cmp_term == m_strm[k]);
      if (ret[k]) rel = rel | m_own[k];
    end
    av = m_free | rel;
    for (int k = 0; k < NK; k++) begin
      nst[k] = m_st[k];
      tk = '0;
      if (m_st[k] == 1 || m_st[k] == 2) begin
        tk = m_need[k] & ~m_own[k] & av;
        av = av & ~tk;
      end
      hitp = pg_valid && m_st[k] != 0 && pg_kid == m_kid[k];
      case (m_st[k])
        1: if (hitp && pg_op == 2'd0) nst[k] = 2;
        2: begin
             if (((m_own[k] | tk) == m_need[k]) && (m_ps[k] || (hitp && pg_op == 2'd1))) nst[k] = 3;
             if (hitp && pg_op == 2'd1) m_ps[k] = 1;
           end
        3: if (hitp && pg_op == 2'd2) nst[k] = 4;
        default: ;
      endcase
      m_own[k] = m_own[k] | tk;
      if (ret[k]) begin nst[k] = 0; m_own[k] = '0; end
    end
    dup = 0; found = 0; slot = 0;
    for (int k = 0; k < NK; k++) begin
      if (m_st[k] != 0 && !ret[k] && m_kid[k] == req_kid) dup = 1;
      if ((m_st[k] == 0 || ret[k]) && !found) begin found = 1; slot = k; end
    end
    for (int k = 0; k < NK; k++) m_st[k] = nst[k];
    grant = req_map & av;
    e_pos = req_valid && (grant != '0) && found && !dup;
    e_neg = req_valid && !e_pos;
    if (e_pos) begin
      m_st[slot] = 1; m_kid[slot] = req_kid; m_need[slot] = req_map;
      m_own[slot] = grant; m_strm[slot] = req_stream; m_ps[slot] = 0;
      av = av & ~grant;
    end
    m_free = av;
  endtask

  // inputs are set at a falling edge; results checked at the next falling edge
  task automatic tick();
    bit h;
    e_qst = model_lookup(qry_kid, h);
    e_hit = h;
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(ack_pos == e_pos && ack_neg == e_neg, "ack pos/neg", {ack_pos, ack_neg}, {e_pos, e_neg});
    if (e_pos || e_neg) check(ack_kid == e_kid, "ack_kid", ack_kid, e_kid);
    check(free_map == m_free, "free_map", free_map, m_free);
    check(qry_hit == e_hit && int'(qry_state) == e_qst, "lookup", {qry_hit, qry_state}, {e_hit, e_qst[2:0]});
  endtask

  task automatic idle();
    flush = 0; req_valid = 0; pg_valid = 0; cmp_valid = 0; pg_op = 2'd3;
  endtask

  task automatic do_req(input int kid, input logic [NC-1:0] map, input bit strm);
    req_valid = 1; req_kid = kid[KW-1:0]; req_map = map; req_stream = strm; qry_kid = kid[KW-1:0];
    tick(); idle();
  endtask

  task automatic do_pg(input int kid, input int op);
    pg_valid = 1; pg_kid = kid[KW-1:0]; pg_op = op[1:0]; qry_kid = kid[KW-1:0];
    tick(); idle(); tick();
  endtask

  task automatic do_cmp(input int kid, input bit term);
    cmp_valid = 1; cmp_kid = kid[KW-1:0]; cmp_term = term; qry_kid = kid[KW-1:0];
    tick(); idle(); tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    tag = "R1";
    check(free_map == '1, "reset free_map", free_map, '1);
    check(!ack_pos && !ack_neg, "reset acks", {ack_pos, ack_neg}, 0);
    check(!qry_hit, "reset lookup", qry_hit, 0);

    tag = "R2"; do_req(1, 16'h000F, 0);
    tag = "R3"; tick();
    tag = "R11"; do_req(1, 16'h0F00, 0);           // identifier already live
    tag = "R2"; do_req(2, 16'h000F, 0);            // nothing free in the bitmap
    tag = "R4"; do_req(2, 16'h00F8, 0);            // takes 0xF0, waits on bit 3
    tag = "R5"; do_pg(2, 0); do_pg(2, 1);          // stays partial: bit 3 missing
    tag = "R5"; do_pg(1, 0); do_pg(1, 1);          // kid 1 complete
    tag = "R6"; do_pg(2, 2);                       // exec start in wrong state
    tag = "R6"; do_pg(1, 3); do_pg(1, 2);
    tag = "R9"; do_cmp(1, 0);                      // frees 0xF, kid 2 grabs bit 3
    tag = "R7"; do_pg(2, 2); do_cmp(2, 1); do_cmp(2, 0);
    tag = "R8"; do_req(3, 16'h3000, 1); do_pg(3, 0); do_pg(3, 1); do_pg(3, 2);
    tag = "R7"; do_cmp(3, 0);                      // streaming: stays
    tag = "R8"; do_cmp(3, 1);
    tag = "R11";
    for (int k = 4; k < 8; k++) do_req(k, 16'h1 << k, 0);
    do_req(9, 16'h8000, 0);                        // table full
    tag = "R10";
    flush = 1; req_valid = 1; req_kid = 4'd10; req_map = 16'hFFFF; tick(); idle(); tick();
    tag = "R9";                                    // release and request in one cycle
    do_req(1, 16'hFFFF, 0); do_pg(1, 0); do_pg(1, 1); do_pg(1, 2);
    cmp_valid = 1; cmp_kid = 4'd1; cmp_term = 0;
    req_valid = 1; req_kid = 4'd2; req_map = 16'h0003; req_stream = 0;
    tick(); idle(); tick();
    flush = 1; tick(); idle();

    tag = "R4";
    for (int n = 0; n < 4000; n++) begin
      flush      = ($urandom_range(0, 99) == 0);
      req_valid  = ($urandom_range(0, 9) < 3);
      req_kid    = $urandom_range(0, 5);
      req_map    = $urandom & $urandom;
      req_stream = $urandom_range(0, 1);
      pg_valid   = ($urandom_range(0, 9) < 5);
      pg_kid     = $urandom_range(0, 5);
      pg_op      = $urandom_range(0, 3);
      cmp_valid  = ($urandom_range(0, 9) < 3);
      cmp_kid    = $urandom_range(0, 5);
      cmp_term   = $urandom_range(0, 1);
      qry_kid    = $urandom_range(0, 5);
      tick();
    end
    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule